// File: doc/BRIEF.md
# Master-Mode Voice PCM Serial Port

This block drives a mono voice channel over a four-wire PCM serial link as the clock master. It derives the bit clock and a one-bit-wide frame sync from a system clock enable (`tick`) that pulses 64 times per frame. Each frame, it shifts out one 16-bit transmit sample MSB first and shifts in one 16-bit receive sample MSB first.

Four static control inputs set the link format:
- the bit clock rate, 16 or 32 bit clocks per frame;
- which bit clock edge launches data and which edge samples it;
- whether the sync pulse leads the first data bit by half a bit clock or by a full bit clock;
- a disable that forces the serial output low.

Control changes are latched only at a frame boundary, so a frame is never built from mixed settings. The transmit word is taken from `tx_data` at each frame boundary, and `tx_take` acknowledges the take. A received word appears on `rx_data` with a one-cycle `rx_valid` strobe.

Terms used below:
- A "launch edge" is the bit clock edge on which `sdo` may change.
- A "capture edge" is the opposite edge, on which `sdi` is sampled.
- The "frame boundary" is the launch edge that starts data bit 0. It is the only launch edge at which `fsync` was already high.

Top module: `pcm_voice_port`

## Requirements
- R1: While `rst_n` is low, `bclk`, `fsync`, `sdo`, `tx_take` and `rx_valid` are 0, and all latched control settings are 0.
- R2: Every frame spans exactly 64 `tick` pulses. A frame latched with `cfg_rate32`=0 holds 16 launch edges; one latched with `cfg_rate32`=1 holds 32.
- R3: With `cfg_bclk_inv`=0 the launch edge is the rising edge of `bclk` and the capture edge is the falling edge; with 1 the two are swapped. `sdo` changes only on launch edges.
- R4: With `cfg_sync_early`=0, `fsync` rises on the capture edge half a bit clock before the boundary. With 1, it rises on the launch edge one bit clock before the boundary.
- R5: `fsync` stays high for exactly one bit clock period (two `bclk` edges) and changes only together with `bclk`.
- R6: Launch slots 0 to 15 after the boundary carry the taken `tx_data` word MSB first, and slots 16 to 31 carry 0. `tx_take` pulses for one clock exactly at each boundary, and the word taken is the `tx_data` value held before that pulse.
- R7: The 16 bits sampled on the capture edges of slots 0 to 15 form `rx_data` MSB first. `rx_valid` pulses for one clock exactly once per frame, after the slot 15 capture. `sdi` in slots 16 to 31 has no effect on `rx_data`.
- R8: For a frame latched with `cfg_sdo_off`=1, `sdo` is 0 on every launch slot.
- R9: A change on any control input takes effect only at the next frame boundary. The frame in progress keeps its length, sync phase and output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable at 64 times the frame rate |
| cfg_rate32 | input | 1 | 0: 16 bit clocks per frame, 1: 32 |
| cfg_bclk_inv | input | 1 | 0: launch on rising edge, 1: launch on falling edge |
| cfg_sync_early | input | 1 | 0: sync leads by half a bit, 1: by a full bit |
| cfg_sdo_off | input | 1 | 1: hold serial output low |
| tx_data | input | SW | Transmit sample |
| tx_take | output | 1 | One-clock pulse when the transmit sample is taken |
| sdi | input | 1 | Serial receive data |
| rx_data | output | SW | Last received sample |
| rx_valid | output | 1 | One-clock pulse when rx_data is updated |
| bclk | output | 1 | Generated bit clock |
| fsync | output | 1 | Generated frame sync |
| sdo | output | 1 | Serial transmit data |

## Verification
The hardest situation to reach from the ports is a control change landing partway through a frame: the frame in flight must finish with its old length, sync phase and output enable, and the next frame must switch cleanly. The bench reaches it by flipping rate, sync phase and disable at random cycles, while `tick` arrives with random gaps. Its expected settings advance only on `tx_take`. A far-end model drives `sdi` on each launch edge it sees and fills the unused 32-slot bits with noise. Each polarity and phase combination is also run from reset at both rates.

// File: rtl/pcm_voice_port.sv
module pcm_voice_port #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_rate32,
  input  logic          cfg_bclk_inv,
  input  logic          cfg_sync_early,
  input  logic          cfg_sdo_off,
  input  logic [SW-1:0] tx_data,
  output logic          tx_take,
  input  logic          sdi,
  output logic [SW-1:0] rx_data,
  output logic          rx_valid,
  output logic          bclk,
  output logic          fsync,
  output logic          sdo
);

  localparam int HW = $clog2(4*SW);
  localparam int KW = HW - 1;
  localparam logic [HW-1:0] LAST16 = HW'(2*SW-1);
  localparam logic [HW-1:0] LAST32 = HW'(4*SW-1);
  localparam logic [HW-1:0] ONE = HW'(1);

  logic [HW-1:0] hc, hn, last, n_last;
  logic [KW-1:0] k;
  logic [SW-1:0] txr, txn, rxs;
  logic pre, r_rate, r_inv, r_early, r_off, fs_hold;
  logic adv, wrap, n_rate, n_inv, n_early, n_off, start, in_data;

  assign adv     = tick & (r_rate | pre);
  assign last    = r_rate ? LAST32 : LAST16;
  assign wrap    = (hc == last);
  assign hn      = wrap ? '0 : hc + ONE;
  assign k       = hn[HW-1:1];
  assign in_data = (k < KW'(SW));

  assign n_rate  = wrap ? cfg_rate32     : r_rate;
  assign n_inv   = wrap ? cfg_bclk_inv   : r_inv;
  assign n_early = wrap ? cfg_sync_early : r_early;
  assign n_off   = wrap ? cfg_sdo_off    : r_off;
  assign n_last  = n_rate ? LAST32 : LAST16;
  assign start   = n_early ? (hn == n_last - ONE) : (hn == n_last);

  assign txn = wrap  ? tx_data :
               hn[0] ? txr     : {txr[SW-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc       <= LAST16;
      pre      <= 1'b0;
      r_rate   <= 1'b0;
      r_inv    <= 1'b0;
      r_early  <= 1'b0;
      r_off    <= 1'b0;
      bclk     <= 1'b0;
      fsync    <= 1'b0;
      fs_hold  <= 1'b0;
      sdo      <= 1'b0;
      txr      <= '0;
      rxs      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      if (tick) pre <= r_rate ? 1'b0 : ~pre;
      if (adv) begin
        hc   <= hn;
        txr  <= txn;
        bclk <= hn[0] ~^ n_inv;
        sdo  <= ~n_off & txn[SW-1];
        if (wrap) begin
          r_rate  <= cfg_rate32;
          r_inv   <= cfg_bclk_inv;
          r_early <= cfg_sync_early;
          r_off   <= cfg_sdo_off;
          tx_take <= 1'b1;
        end
        if (start) begin
          fsync   <= 1'b1;
          fs_hold <= 1'b1;
        end else if (fs_hold) begin
          fs_hold <= 1'b0;
        end else begin
          fsync <= 1'b0;
        end
        if (hn[0] && in_data) begin
          rxs <= {rxs[SW-2:0], sdi};
          if (k == KW'(SW-1)) begin
            rx_data  <= {rxs[SW-2:0], sdi};
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);

  // R8
  sdo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_off |-> !sdo);

  // R3
  launch_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (bclk == !r_inv));

  // R3
  capture_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (bclk == r_inv));

endmodule

// File: tb/test_pcm_voice_port.sv
module test_pcm_voice_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rate = 1'b0, inv = 1'b0, early = 1'b0, off = 1'b0;
  logic sdi = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic tx_take, rx_valid, bclk, fsync, sdo;
  logic [15:0] rx_data;

  pcm_voice_port #(.SW(16)) i_pcm_voice_port (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_rate32(rate), .cfg_bclk_inv(inv), .cfg_sync_early(early), .cfg_sdo_off(off),
    .tx_data(tx_data), .tx_take(tx_take), .sdi(sdi),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .bclk(bclk), .fsync(fsync), .sdo(sdo)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, dens = 100, nbound = 0;
  bit done = 0;

  bit pb, pf, ps, synced, rx_armed;
  bit act_rate, act_ph, act_dis, act_pol, prev_rate, prev_ph;
  int j, fs_run, nvalid, tcnt;
  logic [15:0] loaded, cur_tx, rxw;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_sdo(input bit dis, input logic [15:0] w, input int idx);
    if (dis || idx >= 16) return 1'b0;
    return w[15-idx];
  endfunction

  function automatic int launches(input bit r32);
    return r32 ? 32 : 16;
  endfunction

  function automatic int sync_lead(input bit e);
    return e ? 2 : 1;
  endfunction

  task automatic step();
    bit ed, launch, boundary;
    if (!rst_n) begin
      pb = 0; pf = 0; ps = 0; synced = 0; rx_armed = 0;
      act_rate = 0; act_ph = 0; act_dis = 0; act_pol = inv;
      prev_rate = 0; prev_ph = 0; j = 0; fs_run = 0; nvalid = 0; tcnt = 0;
      return;
    end
    tcnt += int'(tick);
    if (tx_take) begin
      prev_ph = act_ph; prev_rate = act_rate;
      act_rate = rate; act_ph = early; act_dis = off;
      loaded = tx_data;
      tx_data = 16'($urandom);
    end
    ed = (bclk != pb);
    launch = ed && (bclk == !act_pol);
    boundary = launch && pf;
    if (boundary) begin
      chk(tx_take, "R6 take at boundary", int'(tx_take), 1);
      if (synced) begin
        chk(j == launches(prev_rate) - 1, "R2/R9 launches per frame", j + 1, launches(prev_rate));
        chk(tcnt == 64, "R2 ticks per frame", tcnt, 64);
        chk(fs_run == sync_lead(prev_ph), "R4/R9 sync lead edges", fs_run, sync_lead(prev_ph));
        chk(nvalid == 1, "R7 one rx_valid per frame", nvalid, 1);
      end
      nbound++;
      synced = 1; j = 0; nvalid = 0; tcnt = 0;
      cur_tx = loaded; rxw = 16'($urandom); rx_armed = 1;
    end else begin
      if (launch) j++;
      if (tx_take && synced) chk(0, "R6/R9 take away from boundary", 1, 0);
    end
    if (synced && launch) begin
      chk(sdo == exp_sdo(act_dis, cur_tx, j), act_dis ? "R8/R9 sdo held low" : "R6 sdo slot bit",
          int'(sdo), int'(exp_sdo(act_dis, cur_tx, j)));
      sdi = (j < 16) ? rxw[15-j] : 1'($urandom);
    end
    if (synced && !launch) chk(sdo == ps, "R3 sdo moves only on launch edge", int'(sdo), int'(ps));
    if (ed) begin
      if (synced && fsync && !pf) chk(launch == act_ph, "R4 sync rise edge kind", int'(launch), int'(act_ph));
      if (synced && !fsync && pf) chk(fs_run == 2, "R5 sync width", fs_run, 2);
      if (fsync && !pf) fs_run = 1;
      else if (fsync) fs_run++;
    end else if (synced) begin
      chk(fsync == pf, "R5 sync moves only with bclk", int'(fsync), int'(pf));
    end
    if (rx_valid) begin
      nvalid++;
      if (rx_armed) chk(rx_data == rxw, "R7 rx word", int'(rx_data), int'(rxw));
    end
    pb = bclk; pf = fsync; ps = sdo;
  endtask

  initial forever begin
    @(negedge clk);
    step();
  end

  initial forever begin
    @(negedge clk);
    #1 tick = ($urandom_range(0, 99) < dens);
  end

  task automatic do_reset(input bit r, input bit i, input bit e, input bit o);
    @(negedge clk);
    #1 rst_n = 0; rate = r; inv = i; early = e; off = o;
    repeat (3) @(negedge clk);
    chk({bclk, fsync, sdo, tx_take, rx_valid} == 5'b0, "R1 outputs low in reset",
        int'({bclk, fsync, sdo, tx_take, rx_valid}), 0);
    #1 rst_n = 1;
  endtask

  task automatic run_frames(input int n);
    int target;
    target = nbound + n;
    while (nbound < target) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    dens = 100;
    do_reset(0, 0, 0, 0);
    run_frames(6);
    for (int c = 0; c < 8; c++) begin
      dens = $urandom_range(40, 100);
      do_reset(c[0], c[1], c[2], 0);
      run_frames(5);
    end
    do_reset(1, 0, 1, 1);
    run_frames(3);
    @(negedge clk); #1 off = 0;
    run_frames(3);
    for (int p = 0; p < 2; p++) begin
      dens = 75;
      do_reset(0, p[0], 0, 0);
      run_frames(2);
      for (int n = 0; n < 40; n++) begin
        repeat ($urandom_range(1, 150)) @(negedge clk);
        #1;
        rate = 1'($urandom); early = 1'($urandom); off = 1'($urandom);
        dens = $urandom_range(30, 100);
      end
      run_frames(3);
    end
    finish_run();
  end
endmodule